// File: doc/BRIEF.md
# Frame Buffer Region Allocator

This block keeps the accounts for a frame buffer that is split into reserved regions and one common pool. A frame first occupies a slot in a holding area while it waits for classification. Once its class (0 to 7) and source port (0 to 26) are known, an allocation request asks where the frame may be stored. The allocator tries three places in a fixed order. It tries the reservation of the frame's class first, then the common pool, then the reservation of the frame's source port. The first place with room is charged. If none has room, the frame is dropped.

Only classes 2 to 7 have a class reservation, and each of the six has its own programmable size. Classes 0 and 1 start at the common pool. The size of a port reservation is set by one input for the 1 Gbps ports (24 and 25). A second input sets it for every other port, including the CPU port 16. Whoever consumes the response keeps the region code next to the frame. When the frame leaves the buffer, a release request with that code returns the slot to the counter that was charged.

The response comes from a small state machine that holds one state per outcome. From any state it moves to `ST_CLASS`, `ST_SHARED`, `ST_PORT` or `ST_DROP` in the cycle after an allocation request, according to the outcome. It moves to `ST_IDLE` when there is no request. Reset places it in `ST_IDLE`.

Top module: `fba_alloc`

## Requirements
- R1: After reset, `resp_valid`, `tmp_full` and `arr_ok` are low, and every region counter is zero.
- R2: A response appears exactly one cycle after each allocation request, and at no other time. The region codes are 0 for the class section, 1 for the shared pool, 2 for the port section and 3 for drop.
- R3: Classes 0 and 1 are never charged to a class section. Their first choice is the shared pool.
- R4: A request of class 2 to 7 is charged to its class section while that section holds fewer slots than its programmed size. Otherwise it falls to the shared pool. The size for class c sits at bits [(c-2)*W +: W] of `cfg_cls_slots`.
- R5: When the shared pool is full, the request is charged to its source-port section. Ports 24 and 25 use `cfg_port_slots_gig`. All other ports, including port 16, use `cfg_port_slots_std`.
- R6: When all three candidate regions are full, the response is drop (code 3) and no counter changes.
- R7: A release decrements the counter of the region it names (class or port index taken from `rel_cls` or `rel_port`), which frees room for a later request. A release of a counter that is already zero is ignored.
- R8: A release and an allocation in the same cycle are both applied. The allocation is decided on the occupancy before the release.
- R9: An arrival is accepted (`arr_ok`) while the holding area holds fewer frames than `cfg_tmp_slots`. `tmp_full` is high when it does not. Every allocation request, whether placed or dropped, removes one frame from the holding area.
- R10: Each of the six reserved classes is accounted separately, so filling one class section does not change the room in another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_cls_slots | input | 6*W | Reservation size for each of classes 2..7 |
| cfg_shared_slots | input | W | Shared pool size |
| cfg_port_slots_std | input | W | Port reservation size for 10/100 ports and the CPU port |
| cfg_port_slots_gig | input | W | Port reservation size for ports 24 and 25 |
| cfg_tmp_slots | input | W | Holding area size |
| arr_req | input | 1 | A frame asks to enter the holding area |
| arr_ok | output | 1 | The arrival is accepted this cycle |
| tmp_full | output | 1 | The holding area is at capacity |
| alloc_req | input | 1 | Allocation request for a classified frame |
| alloc_cls | input | 3 | Frame class |
| alloc_port | input | 5 | Frame source port |
| resp_valid | output | 1 | Allocation outcome is valid |
| resp_region | output | 2 | Outcome: 0 class, 1 shared, 2 port, 3 drop |
| rel_req | input | 1 | Release one slot |
| rel_region | input | 2 | Region code of the slot being released |
| rel_cls | input | 3 | Class of the released frame |
| rel_port | input | 5 | Source port of the released frame |

## Verification
The first pattern sends repeated requests of one reserved class. This separates charging the class section from falling to the shared pool once that section is full. The second pattern sends class 0 and 1 requests. These show whether a low class skips the class stage and uses the pool. With the pool full, requests from ports 0, 16 and 24 show whether each port gets the right reservation size. A request that follows a drop shows whether counters stayed untouched. Releases, including one on an empty counter and one in the same cycle as a request, show whether the right counter is decremented and when the change takes effect.

// File: rtl/fba_pkg.sv
package fba_pkg;
    typedef enum logic [1:0] {
        RG_CLASS  = 2'd0,
        RG_SHARED = 2'd1,
        RG_PORT   = 2'd2,
        RG_DROP   = 2'd3
    } region_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CLASS,
        ST_SHARED,
        ST_PORT,
        ST_DROP
    } resp_state_e;
endpackage

// File: rtl/fba_cnt_bank.sv
module fba_cnt_bank #(
    parameter int N  = 8,
    parameter int W  = 10,
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inc_en,
    input  logic [IW-1:0]     inc_idx,
    input  logic              dec_en,
    input  logic [IW-1:0]     dec_idx,
    output logic [N-1:0][W-1:0] cnt
);
    for (genvar i = 0; i < N; i++) begin : g_cnt
        logic up, dn;
        assign up = inc_en && (32'(inc_idx) == i);
        assign dn = dec_en && (32'(dec_idx) == i) && (cnt[i] != '0);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cnt[i] <= '0;
            end else if (up && !dn) begin
                cnt[i] <= cnt[i] + W'(1);
            end else if (dn && !up) begin
                cnt[i] <= cnt[i] - W'(1);
            end
        end
    end

    // R6: a cycle with no charge and no release leaves every counter unchanged
    a_r6_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc_en && !dec_en) |=> $stable(cnt));

    // R7: a lone release of a non-empty counter lowers it by one
    a_r7_release_lowers: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_en && !inc_en && (32'(dec_idx) < N) && (cnt[dec_idx] != '0))
        |=> (cnt[$past(dec_idx)] == $past(cnt[dec_idx]) - W'(1)));
endmodule

// File: rtl/fba_policy.sv
module fba_policy
    import fba_pkg::*;
#(
    parameter int W = 10
) (
    input  logic [W-1:0] cls_cnt,
    input  logic [W-1:0] cls_lim,
    input  logic [W-1:0] sh_cnt,
    input  logic [W-1:0] sh_lim,
    input  logic         port_valid,
    input  logic [W-1:0] port_cnt,
    input  logic [W-1:0] port_lim,
    output region_e      choice
);
    logic cls_room, sh_room, port_room;

    assign cls_room  = cls_cnt < cls_lim;
    assign sh_room   = sh_cnt < sh_lim;
    assign port_room = port_valid && (port_cnt < port_lim);

    always_comb begin
        if (cls_room)       choice = RG_CLASS;
        else if (sh_room)   choice = RG_SHARED;
        else if (port_room) choice = RG_PORT;
        else                choice = RG_DROP;
    end
endmodule

// File: rtl/fba_alloc.sv
module fba_alloc
    import fba_pkg::*;
#(
    parameter int W           = 10,
    parameter int NUM_CLASSES = 8,
    parameter int NUM_LOW     = 2,
    parameter int NUM_PORTS   = 27,
    parameter int GIG_FIRST   = 24,
    parameter int GIG_LAST    = 25,
    localparam int NUM_RSV    = NUM_CLASSES - NUM_LOW,
    localparam int CW         = $clog2(NUM_CLASSES),
    localparam int PW         = $clog2(NUM_PORTS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_RSV*W-1:0] cfg_cls_slots,
    input  logic [W-1:0]         cfg_shared_slots,
    input  logic [W-1:0]         cfg_port_slots_std,
    input  logic [W-1:0]         cfg_port_slots_gig,
    input  logic [W-1:0]         cfg_tmp_slots,
    input  logic                 arr_req,
    output logic                 arr_ok,
    output logic                 tmp_full,
    input  logic                 alloc_req,
    input  logic [CW-1:0]        alloc_cls,
    input  logic [PW-1:0]        alloc_port,
    output logic                 resp_valid,
    output logic [1:0]           resp_region,
    input  logic                 rel_req,
    input  logic [1:0]           rel_region,
    input  logic [CW-1:0]        rel_cls,
    input  logic [PW-1:0]        rel_port
);
    logic [NUM_CLASSES-1:0][W-1:0] cls_cnt;
    logic [NUM_CLASSES-1:0][W-1:0] cls_lim;
    logic [NUM_PORTS-1:0][W-1:0]   port_cnt;
    logic [0:0][W-1:0]             sh_cnt;
    logic [0:0][W-1:0]             tmp_cnt;

    for (genvar c = 0; c < NUM_CLASSES; c++) begin : g_lim
        if (c < NUM_LOW) begin : g_none
            assign cls_lim[c] = '0;
        end else begin : g_rsv
            assign cls_lim[c] = cfg_cls_slots[(c-NUM_LOW)*W +: W];
        end
    end

    logic         port_valid, port_gig;
    logic [W-1:0] port_cnt_sel, port_lim_sel;
    region_e      choice;

    assign port_valid   = 32'(alloc_port) < NUM_PORTS;
    assign port_gig     = (alloc_port >= PW'(GIG_FIRST)) && (alloc_port <= PW'(GIG_LAST));
    assign port_cnt_sel = port_valid ? port_cnt[alloc_port] : '0;
    assign port_lim_sel = port_gig ? cfg_port_slots_gig : cfg_port_slots_std;

    fba_policy #(.W(W)) u_policy (
        .cls_cnt   (cls_cnt[alloc_cls]),
        .cls_lim   (cls_lim[alloc_cls]),
        .sh_cnt    (sh_cnt[0]),
        .sh_lim    (cfg_shared_slots),
        .port_valid(port_valid),
        .port_cnt  (port_cnt_sel),
        .port_lim  (port_lim_sel),
        .choice    (choice)
    );

    logic chg_cls, chg_sh, chg_port;
    assign chg_cls  = alloc_req && (choice == RG_CLASS);
    assign chg_sh   = alloc_req && (choice == RG_SHARED);
    assign chg_port = alloc_req && (choice == RG_PORT);

    fba_cnt_bank #(.N(NUM_CLASSES), .W(W)) u_cls_bank (
        .clk(clk), .rst_n(rst_n),
        .inc_en(chg_cls), .inc_idx(alloc_cls),
        .dec_en(rel_req && (rel_region == RG_CLASS)), .dec_idx(rel_cls),
        .cnt(cls_cnt)
    );

    fba_cnt_bank #(.N(1), .W(W)) u_sh_bank (
        .clk(clk), .rst_n(rst_n),
        .inc_en(chg_sh), .inc_idx(1'b0),
        .dec_en(rel_req && (rel_region == RG_SHARED)), .dec_idx(1'b0),
        .cnt(sh_cnt)
    );

    fba_cnt_bank #(.N(NUM_PORTS), .W(W)) u_port_bank (
        .clk(clk), .rst_n(rst_n),
        .inc_en(chg_port), .inc_idx(alloc_port),
        .dec_en(rel_req && (rel_region == RG_PORT)), .dec_idx(rel_port),
        .cnt(port_cnt)
    );

    // holding area for frames awaiting classification
    assign tmp_full = tmp_cnt[0] >= cfg_tmp_slots;
    assign arr_ok   = arr_req && !tmp_full;

    fba_cnt_bank #(.N(1), .W(W)) u_tmp_bank (
        .clk(clk), .rst_n(rst_n),
        .inc_en(arr_ok), .inc_idx(1'b0),
        .dec_en(alloc_req), .dec_idx(1'b0),
        .cnt(tmp_cnt)
    );

    // response state machine
    resp_state_e state_q, state_d;

    always_comb begin
        state_d = ST_IDLE;
        if (alloc_req) begin
            unique case (choice)
                RG_CLASS:  state_d = ST_CLASS;
                RG_SHARED: state_d = ST_SHARED;
                RG_PORT:   state_d = ST_PORT;
                RG_DROP:   state_d = ST_DROP;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        resp_valid  = 1'b1;
        resp_region = RG_DROP;
        unique case (state_q)
            ST_IDLE:   begin resp_valid = 1'b0; resp_region = RG_DROP; end
            ST_CLASS:  resp_region = RG_CLASS;
            ST_SHARED: resp_region = RG_SHARED;
            ST_PORT:   resp_region = RG_PORT;
            ST_DROP:   resp_region = RG_DROP;
            default:   begin resp_valid = 1'b0; resp_region = RG_DROP; end
        endcase
    end

    // R2: exactly one response per request, one cycle later
    a_r2_resp_follows: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_req |=> resp_valid);
    a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !alloc_req |=> !resp_valid);

    // R3: low classes never land in a class section
    a_r3_low_class: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_req && (32'(alloc_cls) < NUM_LOW)) |=> (resp_region != RG_CLASS));

    // R9: an accepted arrival with no departure grows the holding count
    a_r9_tmp_grow: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_ok && !alloc_req) |=> (tmp_cnt[0] == $past(tmp_cnt[0]) + W'(1)));
endmodule

// File: tb/fba_alloc_tb_top.sv
`timescale 1ns/1ps
module fba_alloc_tb_top;
    localparam int W = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic [6*W-1:0] cfg_cls_slots;
    logic [W-1:0] cfg_shared_slots, cfg_port_slots_std, cfg_port_slots_gig, cfg_tmp_slots;
    logic arr_req = 0, arr_ok, tmp_full;
    logic alloc_req = 0;
    logic [2:0] alloc_cls = 0;
    logic [4:0] alloc_port = 0;
    logic resp_valid;
    logic [1:0] resp_region;
    logic rel_req = 0;
    logic [1:0] rel_region = 0;
    logic [2:0] rel_cls = 0;
    logic [4:0] rel_port = 0;

    fba_alloc dut_i (
        .clk(clk), .rst_n(rst_n),
        .cfg_cls_slots(cfg_cls_slots), .cfg_shared_slots(cfg_shared_slots),
        .cfg_port_slots_std(cfg_port_slots_std), .cfg_port_slots_gig(cfg_port_slots_gig),
        .cfg_tmp_slots(cfg_tmp_slots),
        .arr_req(arr_req), .arr_ok(arr_ok), .tmp_full(tmp_full),
        .alloc_req(alloc_req), .alloc_cls(alloc_cls), .alloc_port(alloc_port),
        .resp_valid(resp_valid), .resp_region(resp_region),
        .rel_req(rel_req), .rel_region(rel_region), .rel_cls(rel_cls), .rel_port(rel_port)
    );

    int tests = 0, fails = 0;

    // bench model of occupancy built from the requirements
    int m_cls_lim[8];
    int m_cls[8];
    int m_sh = 0;
    int m_port[27];

    logic [1:0] exp_q[$];
    string tag_q[$];

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // monitor: pop expected outcome whenever a response shows up
    always @(negedge clk) begin
        if (rst_n && resp_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R2 unexpected response", int'(resp_region), -1);
            end else begin
                logic [1:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(resp_region == e, t, int'(resp_region), int'(e));
            end
        end
    end

    function automatic logic [1:0] predict(input int c, input int p);
        int plim;
        plim = (p == 24 || p == 25) ? 2 : 1;
        if (m_cls[c] < m_cls_lim[c]) return 2'd0;
        if (m_sh < 3) return 2'd1;
        if (m_port[p] < plim) return 2'd2;
        return 2'd3;
    endfunction

    task automatic do_alloc(input int c, input int p, input string tag,
                            input bit rel = 0, input int rreg = 0,
                            input int rc = 0, input int rp = 0);
        logic [1:0] e;
        e = predict(c, p);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        alloc_req = 1; alloc_cls = 3'(c); alloc_port = 5'(p);
        rel_req = rel; rel_region = 2'(rreg); rel_cls = 3'(rc); rel_port = 5'(rp);
        if (rel) begin
            if (rreg == 0 && m_cls[rc] > 0) m_cls[rc]--;
            if (rreg == 1 && m_sh > 0) m_sh--;
            if (rreg == 2 && m_port[rp] > 0) m_port[rp]--;
        end
        if (e == 2'd0) m_cls[c]++;
        if (e == 2'd1) m_sh++;
        if (e == 2'd2) m_port[p]++;
        @(negedge clk);
        alloc_req = 0; rel_req = 0;
    endtask

    task automatic do_release(input int rreg, input int rc, input int rp);
        rel_req = 1; rel_region = 2'(rreg); rel_cls = 3'(rc); rel_port = 5'(rp);
        if (rreg == 0 && m_cls[rc] > 0) m_cls[rc]--;
        if (rreg == 1 && m_sh > 0) m_sh--;
        if (rreg == 2 && m_port[rp] > 0) m_port[rp]--;
        @(negedge clk);
        rel_req = 0;
    endtask

    initial begin
        // class 2..6 hold 2 slots, class 7 holds 1; shared 3; std port 1; gig port 2; hold area 4
        for (int c = 0; c < 8; c++) m_cls_lim[c] = (c < 2) ? 0 : ((c == 7) ? 1 : 2);
        for (int c = 0; c < 8; c++) m_cls[c] = 0;
        for (int p = 0; p < 27; p++) m_port[p] = 0;
        for (int c = 2; c < 8; c++) cfg_cls_slots[(c-2)*W +: W] = W'(m_cls_lim[c]);
        cfg_shared_slots = 3; cfg_port_slots_std = 1; cfg_port_slots_gig = 2; cfg_tmp_slots = 4;

        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check(resp_valid == 0, "R1 resp_valid after reset", resp_valid, 0);
        check(tmp_full == 0, "R1 tmp_full after reset", tmp_full, 0);
        check(arr_ok == 0, "R1 arr_ok after reset", arr_ok, 0);

        // R9: holding area fills at four frames
        for (int k = 0; k < 4; k++) begin
            arr_req = 1; #1;
            check(arr_ok == 1, "R9 arrival accepted", arr_ok, 1);
            @(negedge clk);
        end
        #1;
        check(arr_ok == 0, "R9 arrival refused when full", arr_ok, 0);
        check(tmp_full == 1, "R9 tmp_full at capacity", tmp_full, 1);
        arr_req = 0;

        // R4/R2: class 2 fills its section then spills to shared
        do_alloc(2, 0, "R4 class2 first slot");
        #1;
        check(tmp_full == 0, "R9 allocation frees holding slot", tmp_full, 0);
        do_alloc(2, 0, "R4 class2 second slot");
        do_alloc(2, 0, "R4 class2 spills to shared");
        // R3: low classes go to shared
        do_alloc(0, 1, "R3 class0 uses shared");
        do_alloc(1, 1, "R3 class1 uses shared");
        // R5: shared full -> port sections
        do_alloc(2, 0, "R5 std port reservation");
        do_alloc(2, 0, "R6 all full drops");
        do_alloc(2, 0, "R6 drop left counters unchanged");
        do_alloc(0, 24, "R5 gig port first");
        do_alloc(0, 24, "R5 gig port second");
        do_alloc(0, 24, "R5 gig port exhausted");
        do_alloc(1, 16, "R5 cpu port std size");
        do_alloc(1, 16, "R5 cpu port exhausted");
        // R10: every reserved class accounted separately
        do_alloc(7, 5, "R10 class7 section");
        do_alloc(7, 5, "R10 class7 full goes to port");
        for (int c = 3; c < 7; c++) do_alloc(c, 6, "R10 independent class section");
        // R7: release shared slot, reuse it
        do_release(1, 0, 0);
        do_alloc(0, 1, "R7 freed shared slot reused");
        // R7: release of empty port counter ignored
        do_release(2, 0, 10);
        do_alloc(0, 10, "R7 port10 one slot");
        do_alloc(0, 10, "R7 empty release ignored");
        // R8: same-cycle release and allocation on class 2
        do_alloc(2, 2, "R8 decided before release", 1, 0, 2, 0);
        do_alloc(2, 3, "R8 release applied");
        @(negedge clk);
        @(negedge clk);
        check(exp_q.size() == 0, "R2 all responses seen", exp_q.size(), 0);
        check(resp_valid == 0, "R2 no response when idle", resp_valid, 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #400000;
        tests++; fails++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule